// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is fixed at elaboration as either edge-sensitive or level-sensitive. Once hardware capture is switched on, requests are latched into a status register. The status register is masked by an enable register to form the pending set. The block reports the lowest-numbered pending line as a vector number. A single interrupt output is raised when a master gate allows it.

Software reaches the block through a simple word-wide read/write port. A write is a one-cycle strobe with a byte address and data. A read is combinational from the address. Four write-side operations keep the interrupt service routine short: acknowledge clears status bits, set-enable and clear-enable change single enable bits without a read-modify-write, and the control register holds the output gate and the capture switch. Software may write the status register directly only while capture is off, which is useful for self-test.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-high reset, status, enable and control read zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: The control register (offset 0x1C) stores only data bits 1:0, where bit 0 gates `irq_out` and bit 1 turns on hardware capture; bits 31:2 read zero.
- R3: A write to the acknowledge offset (0x0C) clears each status bit where the written data has a one, and leaves the other status bits as they were.
- R4: The enable register (0x08) is directly writable. A write to 0x10 ORs the data into enable. A write to 0x14 clears the enable bits where the data has ones. Neither write changes any other enable bit.
- R5: A write to status (0x00) takes effect only while control bit 1 is 0. While bit 1 is 1, the write is ignored.
- R6: The pending register (0x04) always reads status AND enable.
- R7: The vector register (0x18) reads the index of the lowest set pending bit, or 0xFFFFFFFF when no bit is pending.
- R8: `irq_out` is high exactly when control bit 0 is 1 and at least one pending bit is set.
- R9: While control bit 1 is 1, a level-mode input (its `EDGE_SEL` bit is 0) that is high sets its status bit on every clock. If an acknowledge hits that bit in the same cycle, the capture wins.
- R10: An edge-mode input (its `EDGE_SEL` bit is 1) sets its status bit in the cycle its 0-to-1 transition is seen, provided control bit 1 is 1. Holding the input high after an acknowledge does not set the bit again.
- R11: While control bit 1 is 0, inputs never set status bits. An edge-mode input that rose while capture was off is not latched when capture is later turned on.
- R12: Writes to the pending register, to the vector register, to the write-only offsets as stored state, to offsets at or above 0x20, and to addresses with nonzero bits 1:0 change no state. Reads of offsets 0x0C, 0x10, 0x14, of offsets at or above 0x20, and of misaligned addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_in | input | NUM_SRC | Interrupt request lines |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The capture logic is tried with level lines held high across an acknowledge. This shows whether capture has priority over the clear. Edge lines are held high across an acknowledge, which separates a true rising-edge detector from a level latch. An edge line is also raised while capture is off and then kept high when capture turns on, which shows whether the edge history runs while capture is disabled. Status patterns with one bit, with scattered bits, and with bits 0 and 31 together check the vector priority and the all-ones idle value. Writes under both settings of the capture switch, and writes to read-only and unmapped offsets, check the write lockout rules.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] EDGE_SEL = '0,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic              irq_out
);
  localparam logic [2:0] OFS_STAT = 3'd0, OFS_PEND = 3'd1, OFS_ENA = 3'd2, OFS_ACK = 3'd3,
                         OFS_SET  = 3'd4, OFS_CLR  = 3'd5, OFS_VEC = 3'd6, OFS_CTL = 3'd7;

  logic [NUM_SRC-1:0] status_q, enable_q, prev_q, capture, pending;
  logic [1:0]         ctl_q;
  logic [31:0]        vector;
  logic               mapped;
  logic [2:0]         word;

  assign mapped  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:5] == '0);
  assign word    = addr[4:2];
  assign capture = ctl_q[1] ? ((irq_in & ~EDGE_SEL) | (irq_in & ~prev_q & EDGE_SEL)) : '0;
  assign pending = status_q & enable_q;
  assign irq_out = ctl_q[0] && (pending != '0);

  always_comb begin
    vector = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pending[i]) vector = 32'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      ctl_q    <= '0;
      prev_q   <= '0;
    end else begin
      prev_q <= irq_in;
      if (wr_en && mapped && word == OFS_STAT && !ctl_q[1])
        status_q <= wdata[NUM_SRC-1:0] | capture;
      else if (wr_en && mapped && word == OFS_ACK)
        status_q <= (status_q & ~wdata[NUM_SRC-1:0]) | capture;
      else
        status_q <= status_q | capture;
      if (wr_en && mapped) begin
        case (word)
          OFS_ENA: enable_q <= wdata[NUM_SRC-1:0];
          OFS_SET: enable_q <= enable_q | wdata[NUM_SRC-1:0];
          OFS_CLR: enable_q <= enable_q & ~wdata[NUM_SRC-1:0];
          OFS_CTL: ctl_q    <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (mapped) begin
      case (word)
        OFS_STAT: rdata = 32'(status_q);
        OFS_PEND: rdata = 32'(pending);
        OFS_ENA:  rdata = 32'(enable_q);
        OFS_VEC:  rdata = vector;
        OFS_CTL:  rdata = {30'd0, ctl_q};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] EDGE_SEL = '0,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NUM_SRC-1:0] irq_in,
  input logic              irq_out,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic [1:0]        ctl_q,
  input logic [31:0]       vector
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h00), A_ACK = ADDR_W'('h0C), A_CTL = ADDR_W'('h1C);

  p_ctl_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTL) |=> (ctl_q == $past(wdata[1:0])));

  p_ack_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ACK && !ctl_q[1]) |=> ((status_q & $past(wdata[NUM_SRC-1:0])) == '0));

  p_status_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[1] && !(wr_en && addr == A_ACK)) |=> (($past(status_q) & ~status_q) == '0));

  p_status_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STAT && !ctl_q[1]) |=> (status_q == $past(wdata[NUM_SRC-1:0])));

  p_idle_vector_r7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & enable_q) == '0) |-> (vector == 32'hFFFF_FFFF));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (ctl_q[0] && vector != 32'hFFFF_FFFF));

  p_level_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[1] && (irq_in & ~EDGE_SEL) != '0)
      |=> ((status_q & $past(irq_in & ~EDGE_SEL)) == $past(irq_in & ~EDGE_SEL)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC), .EDGE_SEL(EDGE_SEL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq_in(irq_in),
  .irq_out(irq_out), .status_q(status_q), .enable_q(enable_q), .ctl_q(ctl_q), .vector(vector)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;
  localparam logic [5:0] A_STAT = 6'h00, A_PEND = 6'h04, A_ENA = 6'h08, A_ACK = 6'h0C,
                         A_SET = 6'h10, A_CLR = 6'h14, A_VEC = 6'h18, A_CTL = 6'h1C;

  logic clk = 0, rst = 1, wr_en = 0, irq_out;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, irq_in = '0;
  int checks = 0, errors = 0;

  irq_vector_ctrl #(.NUM_SRC(32), .EDGE_SEL(EDGES), .ADDR_W(6)) i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic clean();
    irq_in = '0;
    wr(A_CTL, 0); wr(A_STAT, 0); wr(A_ENA, 0);
  endtask

  task automatic t_reset();
    rd_chk("R1 status", A_STAT, 0);
    rd_chk("R1 enable", A_ENA, 0);
    rd_chk("R1 ctl", A_CTL, 0);
    rd_chk("R1 vector", A_VEC, 32'hFFFF_FFFF);
    check("R1 irq_out", 32'(irq_out), 0);
  endtask

  task automatic t_ctl();
    wr(A_CTL, 32'hFFFF_FFFE);
    rd_chk("R2 upper bits", A_CTL, 32'h2);
    wr(A_CTL, 0);
    rd_chk("R2 cleared", A_CTL, 0);
  endtask

  task automatic t_sw_path();
    wr(A_STAT, 32'h0000_00A4);
    rd_chk("R5 status write open", A_STAT, 32'hA4);
    wr(A_SET, 32'h20); wr(A_SET, 32'h104);
    rd_chk("R4 set-enable", A_ENA, 32'h124);
    wr(A_CLR, 32'h20);
    rd_chk("R4 clear-enable", A_ENA, 32'h104);
    rd_chk("R6 pending", A_PEND, 32'h04);
    rd_chk("R7 vector", A_VEC, 2);
    check("R8 gate off", 32'(irq_out), 0);
    wr(A_CTL, 1);
    #1 check("R8 gate on", 32'(irq_out), 1);
    wr(A_ACK, 32'h04);
    rd_chk("R3 ack", A_STAT, 32'hA0);
    rd_chk("R7 none pending", A_VEC, 32'hFFFF_FFFF);
    check("R8 nothing pending", 32'(irq_out), 0);
    wr(A_ENA, 32'h80);
    rd_chk("R4 direct write", A_ENA, 32'h80);
    rd_chk("R7 bit 7", A_VEC, 7);
  endtask

  task automatic t_lock();
    wr(A_CTL, 3);
    wr(A_STAT, 32'h1);
    rd_chk("R5 status locked", A_STAT, 32'hA0);
    clean();
  endtask

  task automatic t_level();
    wr(A_CTL, 2);
    @(negedge clk); irq_in[3] = 1;
    repeat (2) @(negedge clk);
    rd_chk("R9 level capture", A_STAT, 32'h08);
    wr(A_ACK, 32'h08);
    rd_chk("R9 capture beats ack", A_STAT, 32'h08);
    @(negedge clk); irq_in[3] = 0;
    wr(A_ACK, 32'h08);
    rd_chk("R9 cleared after drop", A_STAT, 0);
    clean();
  endtask

  task automatic t_edge();
    wr(A_CTL, 2);
    @(negedge clk); irq_in[20] = 1;
    @(negedge clk);
    rd_chk("R10 edge capture", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000);
    repeat (3) @(negedge clk);
    rd_chk("R10 no re-set while held", A_STAT, 0);
    @(negedge clk); irq_in[20] = 0;
    @(negedge clk); irq_in[20] = 1;
    @(negedge clk);
    rd_chk("R10 second edge", A_STAT, 32'h0010_0000);
    clean();
  endtask

  task automatic t_disabled();
    @(negedge clk); irq_in[21] = 1; irq_in[4] = 1;
    repeat (2) @(negedge clk);
    rd_chk("R11 no capture when off", A_STAT, 0);
    wr(A_CTL, 2);
    @(negedge clk);
    rd_chk("R11 old edge not latched", A_STAT, 32'h10);
    clean();
  endtask

  task automatic t_vector();
    wr(A_ENA, 32'hFFFF_FFFF);
    wr(A_STAT, 32'h8000_0000);
    rd_chk("R7 top index", A_VEC, 31);
    wr(A_STAT, 32'h8000_0001);
    rd_chk("R7 lowest wins", A_VEC, 0);
    wr(A_STAT, 32'h0001_0400);
    rd_chk("R7 scattered", A_VEC, 10);
    clean();
  endtask

  task automatic t_readonly();
    wr(A_ENA, 32'h0F); wr(A_STAT, 32'h33);
    wr(A_PEND, 32'hFFFF_FFFF); wr(A_VEC, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF); wr(6'h3C, 32'h0); wr(6'h09, 32'h0);
    rd_chk("R12 status untouched", A_STAT, 32'h33);
    rd_chk("R12 enable untouched", A_ENA, 32'h0F);
    rd_chk("R12 ack reads zero", A_ACK, 0);
    rd_chk("R12 set reads zero", A_SET, 0);
    rd_chk("R12 clr reads zero", A_CLR, 0);
    rd_chk("R12 unmapped reads zero", 6'h24, 0);
    rd_chk("R12 misaligned reads zero", 6'h01, 0);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ctl();
    t_sw_path();
    t_lock();
    t_level();
    t_edge();
    t_disabled();
    t_vector();
    t_readonly();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule